// File: doc/BRIEF.md
# Clock Generator Configuration Port over I2C

This block is the two-wire configuration slave of a multi-output clock generator. A bus master uses it to set one selection byte per clock output and one shared frequency-margin byte, and to read any of them back. The bytes leave the block as parallel vectors that steer the output dividers and the margin logic elsewhere on the chip.

The slave answers at one of nine 7-bit addresses. Two strap pins pick the address, and each strap can be low, high or floating. A pad circuit outside this block senses the straps and hands each one in as a 2-bit code. SCL and SDA arrive as raw samples of the pads. They pass through a two-flop synchronizer and a persistence filter before any bus decoding. SDA is driven only by pulling low, through an enable output. Every transfer touches exactly one register. A write carries one register-address byte and then one data byte. A read sets the pointer with a write phase, then issues a repeated START and a read address byte, and receives one byte. The pointer never advances by itself.

There is no streaming interface. The register vectors are plain level outputs that hold their value until the next write, so no valid/ready handshake or back-pressure applies.

Top module: `clkcfg_i2c_regs`

## Requirements
- R1: The device address comes from the straps `strap_a1`/`strap_a0`, coded 00 = tied low, 01 = tied high, 10 or 11 = floating. The pairs (a1,a0) map as follows: float/high 0x62, float/low 0x64, float/float 0x68, low/high 0x70, low/low 0x69, low/float 0x6C, high/high 0x74, high/low 0x72, high/float 0x71. A matching address byte is ACKed.
- R2: A write (START, address+W, register byte n in 0x01..NUM_OUT, data byte, STOP) gets an ACK on all three bytes. The data byte then appears on `clk_sel[8*(n-1) +: 8]`.
- R3: Register NUM_OUT+1 (0x10 by default) holds the margin byte, which appears on `margin_sel`.
- R4: A write to register 0x00 loads the data byte into every per-output register at once and leaves the margin register unchanged.
- R5: A read (write phase with the register byte, repeated START, address+R) returns the register's value MSB first. Reading 0x00 returns the register of output 1.
- R6: Register bytes above NUM_OUT+1 are ACKed. Writes to them change no output, and reads from them return 0x00.
- R7: Only the first data byte of a write is stored. Any further data byte gets a NACK and is dropped. The pointer does not advance, so a second read phase after another repeated START returns the same register.
- R8: An address byte that does not match gets a NACK. The slave then drives nothing and stores nothing until the next START or STOP.
- R9: A level change on SCL or SDA that lasts fewer than FILT_CYC system clocks is filtered out. It creates no bit, START or STOP.
- R10: After reset, every register is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL pad sample |
| sda_in | input | 1 | Raw SDA pad sample |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_a1 | input | 2 | Decoded code of address strap 1 |
| strap_a0 | input | 2 | Decoded code of address strap 0 |
| clk_sel | output | 8*NUM_OUT | Per-output selection bytes, output 1 in the low byte |
| margin_sel | output | 8 | Shared frequency-margin byte |

## Verification
The bench uses the defaults NUM_OUT = 15 and FILT_CYC = 5. At a 100 MHz clock this gives a 50 ns rejection window and puts the margin register at 0x10. Bus quarter-periods of 25 clocks sit well above the filter window. Injected 3-clock pulses sit below it, so both glitch rejection and normal decoding can be tested. Fifteen outputs let the broadcast check cover the whole vector, and they let the reserved-range checks exercise the boundary at 0x11.

// File: rtl/cg_pkg.sv
package cg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_DATA, ST_ACK, ST_TX, ST_SKIP
  } bus_st_e;

  // strap code: 00 low, 01 high, 1x floating
  function automatic logic [1:0] strap_norm(input logic [1:0] code);
    return code[1] ? 2'b10 : code;
  endfunction

  function automatic logic [6:0] strap_to_addr(input logic [1:0] a1, input logic [1:0] a0);
    logic [3:0] key;
    key = {strap_norm(a1), strap_norm(a0)};
    case (key)
      4'b1001: return 7'h62;
      4'b1000: return 7'h64;
      4'b1010: return 7'h68;
      4'b0001: return 7'h70;
      4'b0000: return 7'h69;
      4'b0010: return 7'h6C;
      4'b0101: return 7'h74;
      4'b0100: return 7'h72;
      4'b0110: return 7'h71;
      default: return 7'h68;
    endcase
  endfunction

endpackage

// File: rtl/cg_deglitch.sv
module cg_deglitch #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      clean  <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] != clean) begin
        if (run_q == CW'(FILT_CYC - 1)) begin
          clean <= sync_q[1];
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  // the filtered level only ever moves to the level the synchronizer held
  p_flip_follows_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean) |-> (clean == $past(sync_q[1])));

endmodule

// File: rtl/cg_bus_slave.sv
module cg_bus_slave
  import cg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic [6:0] my_addr,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] reg_ptr
);
  bus_st_e    st, nxt;
  logic       scl_d, sda_d;
  logic [3:0] bits;
  logic [7:0] sh, tx;

  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire rx_st    = (st == ST_DEV) || (st == ST_REG) || (st == ST_DATA);
  wire byte_end = scl_fall && (bits == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      nxt      <= ST_IDLE;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      bits     <= '0;
      sh       <= '0;
      tx       <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      reg_ptr  <= '0;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
      wr_en <= 1'b0;
      if (start_c) begin
        st       <= ST_DEV;
        bits     <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        if (rx_st && scl_rise) begin
          sh   <= {sh[6:0], sda};
          bits <= bits + 1'b1;
        end
        case (st)
          ST_DEV: if (byte_end) begin
            if (sh[7:1] == my_addr) begin
              sda_pull <= 1'b1;
              st       <= ST_ACK;
              nxt      <= sh[0] ? ST_TX : ST_REG;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_REG: if (byte_end) begin
            reg_ptr  <= sh;
            sda_pull <= 1'b1;
            st       <= ST_ACK;
            nxt      <= ST_DATA;
          end
          ST_DATA: if (byte_end) begin
            wr_en    <= 1'b1;
            wr_addr  <= reg_ptr;
            wr_data  <= sh;
            sda_pull <= 1'b1;
            st       <= ST_ACK;
            nxt      <= ST_SKIP;
          end
          ST_ACK: if (scl_fall) begin
            bits <= '0;
            st   <= nxt;
            if (nxt == ST_TX) begin
              tx       <= rd_data;
              sda_pull <= ~rd_data[7];
            end else begin
              sda_pull <= 1'b0;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bits == 4'd7) begin
              sda_pull <= 1'b0;
              st       <= ST_SKIP;
            end else begin
              tx       <= {tx[6:0], 1'b0};
              sda_pull <= ~tx[6];
              bits     <= bits + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_skip_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_pull);

  p_single_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_pull);

endmodule

// File: rtl/cg_regbank.sv
module cg_regbank #(
  parameter int NUM_OUT = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           rd_addr,
  output logic [7:0]           rd_data,
  output logic [NUM_OUT*8-1:0] sel_flat,
  output logic [7:0]           margin
);
  localparam logic [7:0] BCAST  = 8'h00;
  localparam logic [7:0] MARGIN = 8'(NUM_OUT + 1);

  for (genvar i = 1; i <= NUM_OUT; i++) begin : g_out
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && (wr_addr == BCAST || wr_addr == 8'(i)))
        q <= wr_data;
    end
    assign sel_flat[(i-1)*8 +: 8] = q;

    p_bcast_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == BCAST) |=> (sel_flat[(i-1)*8 +: 8] == $past(wr_data)));
    p_single_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 8'(i)) |=> (sel_flat[(i-1)*8 +: 8] == $past(wr_data)));
    p_reserved_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > MARGIN) |=> $stable(sel_flat[(i-1)*8 +: 8]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      margin <= '0;
    else if (wr_en && wr_addr == MARGIN)
      margin <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == MARGIN) rd_data = margin;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (rd_addr == 8'(k + 1) || (k == 0 && rd_addr == BCAST))
        rd_data = sel_flat[k*8 +: 8];
    end
  end

  p_margin_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MARGIN) |=> (margin == $past(wr_data)));
  p_margin_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == BCAST) |=> $stable(margin));

endmodule

// File: rtl/clkcfg_i2c_regs.sv
module clkcfg_i2c_regs
  import cg_pkg::*;
#(
  parameter int NUM_OUT  = 15,
  parameter int FILT_CYC = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_pull,
  input  logic [1:0]           strap_a1,
  input  logic [1:0]           strap_a0,
  output logic [NUM_OUT*8-1:0] clk_sel,
  output logic [7:0]           margin_sel
);
  logic [1:0] raw_lines, clean_lines;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, reg_ptr, rd_data;
  logic [6:0] my_addr;

  assign raw_lines = {scl_in, sda_in};
  assign my_addr   = strap_to_addr(strap_a1, strap_a0);

  for (genvar l = 0; l < 2; l++) begin : g_line
    cg_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[l]),
      .clean(clean_lines[l])
    );
  end

  cg_bus_slave u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (clean_lines[1]),
    .sda     (clean_lines[0]),
    .my_addr (my_addr),
    .rd_data (rd_data),
    .sda_pull(sda_pull),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .reg_ptr (reg_ptr)
  );

  cg_regbank #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (reg_ptr),
    .rd_data (rd_data),
    .sel_flat(clk_sel),
    .margin  (margin_sel)
  );

endmodule

// File: tb/tb_clkcfg_i2c_regs.sv
module tb_clkcfg_i2c_regs;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] s1 = 2'b10, s0 = 2'b10;
  wire sda_pull;
  wire [119:0] sel;
  wire [7:0] marg;
  wire sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_bad = 0;
  logic [6:0] dev = 7'h68;

  always #5 clk = ~clk;

  clkcfg_i2c_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .strap_a1(s1), .strap_a0(s0), .clk_sel(sel), .margin_sel(marg)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_addr(input logic [1:0] a1, input logic [1:0] a0);
    logic [1:0] h, l;
    h = a1[1] ? 2'b10 : a1;
    l = a0[1] ? 2'b10 : a0;
    case ({h, l})
      4'b1001: return 7'h62;  4'b1000: return 7'h64;  4'b1010: return 7'h68;
      4'b0001: return 7'h70;  4'b0000: return 7'h69;  4'b0010: return 7'h6C;
      4'b0101: return 7'h74;  4'b0100: return 7'h72;  default: return 7'h71;
    endcase
  endfunction

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      if (glitch && i == 5) begin scl_m = 1; tick(3); scl_m = 0; tick(Q); end
      scl_m = 1; tick(Q);
      if (glitch && b[i] && i == 3) begin sda_m = 0; tick(3); sda_m = 1; end
      tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = !sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask

  task automatic wr_reg(input logic [6:0] d7, input logic [7:0] ra, input logic [7:0] dat,
                        input bit glitch, output logic [2:0] acks);
    bit a;
    bus_start();
    send_byte({d7, 1'b0}, 1'b0, a); acks[2] = a;
    send_byte(ra, 1'b0, a);         acks[1] = a;
    send_byte(dat, glitch, a);      acks[0] = a;
    bus_stop();
  endtask

  task automatic rd_reg(input logic [6:0] d7, input logic [7:0] ra, output logic [7:0] dat,
                        output logic [2:0] acks);
    bit a;
    bus_start();
    send_byte({d7, 1'b0}, 1'b0, a); acks[2] = a;
    send_byte(ra, 1'b0, a);         acks[1] = a;
    bus_rstart();
    send_byte({d7, 1'b1}, 1'b0, a); acks[0] = a;
    recv_byte(dat);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R10", "sda released", {127'h0, sda_pull}, 128'h0);
    check("R10", "selection regs", {8'h0, sel}, 128'h0);
    check("R10", "margin reg", {120'h0, marg}, 128'h0);
  endtask

  task automatic t_straps();
    logic [2:0] acks;
    logic [1:0] codes [3] = '{2'b00, 2'b01, 2'b10};
    int idx = 0;
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        s1 = codes[a]; s0 = codes[b]; tick(4);
        wr_reg(exp_addr(s1, s0), 8'h01, 8'(idx + 1), 1'b0, acks);
        check("R1", "acks at strap address", {125'h0, acks}, 128'h7);
        check("R1", "reg1 after strap write", {120'h0, sel[7:0]}, 128'(idx + 1));
        idx++;
      end
    end
    s1 = 2'b11; s0 = 2'b11; tick(4);
    wr_reg(7'h68, 8'h01, 8'h2B, 1'b0, acks);
    check("R1", "code 11 reads as floating", {120'h0, sel[7:0]}, 128'h2B);
    s1 = 2'b10; s0 = 2'b10; dev = 7'h68; tick(4);
  endtask

  task automatic t_write();
    logic [2:0] acks;
    wr_reg(dev, 8'h03, 8'h05, 1'b0, acks);
    check("R2", "acks", {125'h0, acks}, 128'h7);
    check("R2", "reg3", {120'h0, sel[23:16]}, 128'h05);
    wr_reg(dev, 8'h0F, 8'h0A, 1'b0, acks);
    check("R2", "reg15", {120'h0, sel[119:112]}, 128'h0A);
  endtask

  task automatic t_margin();
    logic [2:0] acks;
    wr_reg(dev, 8'h10, 8'h06, 1'b0, acks);
    check("R3", "margin", {120'h0, marg}, 128'h06);
  endtask

  task automatic t_bcast();
    logic [2:0] acks;
    wr_reg(dev, 8'h00, 8'h03, 1'b0, acks);
    check("R4", "all outputs", {8'h0, sel}, {8'h0, {15{8'h03}}});
    check("R4", "margin untouched", {120'h0, marg}, 128'h06);
  endtask

  task automatic t_read();
    logic [2:0] acks;
    logic [7:0] d;
    wr_reg(dev, 8'h07, 8'hC3, 1'b0, acks);
    rd_reg(dev, 8'h07, d, acks);
    check("R5", "read acks", {125'h0, acks}, 128'h7);
    check("R5", "read reg7", {120'h0, d}, 128'hC3);
    wr_reg(dev, 8'h01, 8'h08, 1'b0, acks);
    rd_reg(dev, 8'h00, d, acks);
    check("R5", "read 0x00 gives reg1", {120'h0, d}, 128'h08);
    rd_reg(dev, 8'h10, d, acks);
    check("R5", "read margin", {120'h0, d}, 128'h06);
  endtask

  task automatic t_reserved();
    logic [2:0] acks;
    logic [7:0] d;
    logic [119:0] snap;
    logic [7:0] msnap;
    snap = sel; msnap = marg;
    wr_reg(dev, 8'h11, 8'hFF, 1'b0, acks);
    check("R6", "acks on 0x11", {125'h0, acks}, 128'h7);
    wr_reg(dev, 8'hFF, 8'hEE, 1'b0, acks);
    check("R6", "outputs unchanged", {msnap == marg, sel}, {1'b1, snap});
    rd_reg(dev, 8'h40, d, acks);
    check("R6", "reserved read", {120'h0, d}, 128'h00);
  endtask

  task automatic t_burst();
    bit a;
    logic [2:0] acks;
    logic [7:0] d1, d2;
    bus_start();
    send_byte({dev, 1'b0}, 1'b0, a);
    send_byte(8'h02, 1'b0, a);
    send_byte(8'h44, 1'b0, a); acks[2] = a;
    send_byte(8'h55, 1'b0, a); acks[1] = a;
    bus_stop();
    check("R7", "first ack / second nack", {126'h0, acks[2:1]}, 128'h2);
    check("R7", "reg2 and reg3", {112'h0, sel[23:8]}, {112'h0, 8'h03, 8'h44});
    bus_start();
    send_byte({dev, 1'b0}, 1'b0, a);
    send_byte(8'h02, 1'b0, a);
    bus_rstart();
    send_byte({dev, 1'b1}, 1'b0, a);
    recv_byte(d1);
    bus_rstart();
    send_byte({dev, 1'b1}, 1'b0, a);
    recv_byte(d2);
    bus_stop();
    check("R7", "pointer held over two reads", {112'h0, d1, d2}, {112'h0, 8'h44, 8'h44});
  endtask

  task automatic t_mismatch();
    bit a;
    logic [2:0] acks;
    logic [7:0] keep;
    keep = sel[39:32];
    bus_start();
    send_byte({7'h69, 1'b0}, 1'b0, a); acks[2] = a;
    send_byte(8'h05, 1'b0, a);         acks[1] = a;
    send_byte(8'h77, 1'b0, a);         acks[0] = a;
    bus_stop();
    check("R8", "no acks on foreign address", {125'h0, acks}, 128'h0);
    check("R8", "reg5 unchanged", {120'h0, sel[39:32]}, {120'h0, keep});
  endtask

  task automatic t_glitch();
    logic [2:0] acks;
    wr_reg(dev, 8'h09, 8'h5A, 1'b1, acks);
    check("R9", "acks with glitches", {125'h0, acks}, 128'h7);
    check("R9", "reg9 with glitches", {120'h0, sel[71:64]}, 128'h5A);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_straps();
    t_write();
    t_margin();
    t_bcast();
    t_read();
    t_reserved();
    t_burst();
    t_mismatch();
    t_glitch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule